// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between an SDRAM command generator and the memory command bus. It keeps track of every bank: whether a row is open, and how many clock cycles have passed since that bank was last activated. It also counts the cycles since the most recent activation to any bank. Three request ports carry precharge, read/write and activate requests from the generator. The guard sends at most one of them to the command bus in each clock cycle, and only once the row timing limits allow it. The four limits are given at run time as cycle counts, each at least 1:

- the gap from activate to the first access,
- the gap between activates to the same bank,
- the gap between activates to any two banks,
- the longest time a row may stay open.

When a request is acknowledged, it has either been issued or been consumed. A request that only has to wait stays pending and raises its stall output until it can go. A request that can never become legal is consumed without a bus command and is recorded in a sticky violation register. Examples are an access to a closed bank or an activate to a bank that is already open. A row kept open past its limit raises a forced-precharge line for that bank and is also recorded as a violation.

The requester holds each request steady until its acknowledge is seen, and drops it in the following cycle. The acknowledge, stall and command outputs are combinational from the current requests and the registered bank state.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset every bank is idle, every timer reads as long expired, the violation flag is 0 and no forced precharge is raised, so a first activate is issued in the cycle it is requested.
- R2: A read or write to an idle bank is acknowledged without a bus command, and in the next cycle the violation flag is 1 with viol_rule = 1 and viol_bank = that bank.
- R3: A read (cmd_code 1) or write (cmd_code 2) to an open bank is issued exactly t_rcd cycles after that bank's activate, when the access is requested earlier and nothing else competes.
- R4: An activate to an open bank is acknowledged without a bus command and records viol_rule = 2 for that bank.
- R5: An activate (cmd_code 0) to an idle bank is issued no sooner than t_rc cycles after that bank's previous activate.
- R6: An activate is issued no sooner than t_rrd cycles after the previous activate to any bank.
- R7: A bank that has been open for more than t_ras_max cycles drives force_pre for that bank, and in the next cycle the overrun is recorded with viol_rule = 3.
- R8: At most one command is issued per cycle. Priority is precharge, then read/write, then activate; an activate may use the slot only when neither of the other two was acknowledged.
- R9: A request that waits on timing is held with its stall output high and is issued later; it is never dropped.
- R10: The violation register records only the first violation and keeps it until reset.
- R11: A precharge to an idle bank is acknowledged without a bus command and leaves that bank's activate timer unchanged.
- R12: A precharge (cmd_code 3) to an open bank is issued at once and closes the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_rcd | input | CW | Activate-to-access gap in cycles |
| t_rc | input | CW | Same-bank activate spacing in cycles |
| t_rrd | input | CW | Any-bank activate spacing in cycles |
| t_ras_max | input | CW | Longest time a row may stay open, in cycles |
| pre_req | input | 1 | Precharge request |
| pre_bank | input | log2(NB) | Target bank of the precharge |
| rw_req | input | 1 | Read/write request |
| rw_write | input | 1 | 1 = write, 0 = read |
| rw_bank | input | log2(NB) | Target bank of the access |
| act_req | input | 1 | Activate request |
| act_bank | input | log2(NB) | Target bank of the activate |
| pre_ack | output | 1 | Precharge request consumed |
| rw_ack | output | 1 | Read/write request consumed |
| act_ack | output | 1 | Activate request consumed |
| pre_stall | output | 1 | Precharge request pending |
| rw_stall | output | 1 | Read/write request pending |
| act_stall | output | 1 | Activate request pending |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_code | output | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | output | log2(NB) | Bank of the issued command |
| force_pre | output | NB | Per-bank open-time overrun |
| viol_flag | output | 1 | Sticky violation present |
| viol_rule | output | 2 | 1 access to idle, 2 activate to open, 3 overrun |
| viol_bank | output | log2(NB) | Bank of the recorded violation |

## Verification
Two things can fall into the same cycle. The first is a precharge, an access and an activate all requested together: the bench raises all three in one window to banks whose timers have long expired. It then expects three bus commands in successive cycles, in priority order, with the stall outputs of the losers high. The second is a timing gap expiring while a held request waits: the sweeps over t_rcd, t_rc and t_rrd keep a request up from the cycle after the activate and judge the cycle of issue against the programmed count. In the same run a duplicate precharge shows that a no-op does not move the same-bank timer.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        RULE_NONE     = 2'd0,
        RULE_RW_IDLE  = 2'd1,
        RULE_ACT_OPEN = 2'd2,
        RULE_OVERRUN  = 2'd3
    } rule_e;

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          pre_go,
    input  logic          rw_go,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_rc,
    input  logic [CW-1:0] t_ras_max,
    output logic          open_o,
    output logic [CW-1:0] age_o,
    output logic          overrun_o
);
    localparam logic [CW-1:0] AGE_SAT = '1;

    typedef struct packed {
        logic          open;
        logic [CW-1:0] age;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.age != AGE_SAT) st_d.age = st_q.age + 1'b1;
        if (act_go) begin
            st_d.open = 1'b1;
            st_d.age  = CW'(1);
        end
        if (pre_go) st_d.open = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.open <= 1'b0;
            st_q.age  <= AGE_SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o    = st_q.open;
    assign age_o     = st_q.age;
    assign overrun_o = st_q.open && (st_q.age > t_ras_max);

    assert_access_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |-> (st_q.open && st_q.age >= t_rcd));

    assert_act_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (!st_q.open && st_q.age >= t_rc));

    assert_pre_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> !st_q.open);

endmodule

// File: rtl/sdram_guard_arbiter.sv
module sdram_guard_arbiter
    import sdram_guard_pkg::*;
#(
    parameter int NB = 4,
    parameter int CW = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic [NB-1:0]         bank_open,
    input  logic [NB-1:0][CW-1:0] bank_age,
    input  logic [CW-1:0]         any_age,
    input  logic [CW-1:0]         t_rcd,
    input  logic [CW-1:0]         t_rc,
    input  logic [CW-1:0]         t_rrd,
    input  logic                  pre_req,
    input  logic [BW-1:0]         pre_bank,
    input  logic                  rw_req,
    input  logic                  rw_write,
    input  logic [BW-1:0]         rw_bank,
    input  logic                  act_req,
    input  logic [BW-1:0]         act_bank,
    output logic                  pre_ack,
    output logic                  rw_ack,
    output logic                  act_ack,
    output logic                  cmd_valid,
    output cmd_e                  cmd_code,
    output logic [BW-1:0]         cmd_bank,
    output logic [NB-1:0]         pre_go,
    output logic [NB-1:0]         rw_go,
    output logic [NB-1:0]         act_go,
    output logic                  req_viol,
    output rule_e                 req_rule,
    output logic [BW-1:0]         req_bank
);
    always_comb begin
        pre_ack   = 1'b0;
        rw_ack    = 1'b0;
        act_ack   = 1'b0;
        cmd_valid = 1'b0;
        cmd_code  = CMD_ACT;
        cmd_bank  = '0;
        pre_go    = '0;
        rw_go     = '0;
        act_go    = '0;
        req_viol  = 1'b0;
        req_rule  = RULE_NONE;
        req_bank  = '0;

        if (pre_req) begin
            pre_ack = 1'b1;
            if (bank_open[pre_bank]) begin
                cmd_valid        = 1'b1;
                cmd_code         = CMD_PRE;
                cmd_bank         = pre_bank;
                pre_go[pre_bank] = 1'b1;
            end
        end else if (rw_req) begin
            if (!bank_open[rw_bank]) begin
                rw_ack   = 1'b1;
                req_viol = 1'b1;
                req_rule = RULE_RW_IDLE;
                req_bank = rw_bank;
            end else if (bank_age[rw_bank] >= t_rcd) begin
                rw_ack         = 1'b1;
                cmd_valid      = 1'b1;
                cmd_code       = rw_write ? CMD_WR : CMD_RD;
                cmd_bank       = rw_bank;
                rw_go[rw_bank] = 1'b1;
            end
        end

        if (act_req && !pre_ack && !rw_ack) begin
            if (bank_open[act_bank]) begin
                act_ack  = 1'b1;
                req_viol = 1'b1;
                req_rule = RULE_ACT_OPEN;
                req_bank = act_bank;
            end else if (bank_age[act_bank] >= t_rc && any_age >= t_rrd) begin
                act_ack          = 1'b1;
                cmd_valid        = 1'b1;
                cmd_code         = CMD_ACT;
                cmd_bank         = act_bank;
                act_go[act_bank] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_single_grant_R8: assert ($countones({pre_ack, rw_ack, act_ack}) <= 1);
    end

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
    import sdram_guard_pkg::*;
#(
    parameter int NB = 4,
    parameter int CW = 8,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] t_rcd,
    input  logic [CW-1:0] t_rc,
    input  logic [CW-1:0] t_rrd,
    input  logic [CW-1:0] t_ras_max,
    input  logic          pre_req,
    input  logic [BW-1:0] pre_bank,
    input  logic          rw_req,
    input  logic          rw_write,
    input  logic [BW-1:0] rw_bank,
    input  logic          act_req,
    input  logic [BW-1:0] act_bank,
    output logic          pre_ack,
    output logic          rw_ack,
    output logic          act_ack,
    output logic          pre_stall,
    output logic          rw_stall,
    output logic          act_stall,
    output logic          cmd_valid,
    output logic [1:0]    cmd_code,
    output logic [BW-1:0] cmd_bank,
    output logic [NB-1:0] force_pre,
    output logic          viol_flag,
    output logic [1:0]    viol_rule,
    output logic [BW-1:0] viol_bank
);
    localparam logic [CW-1:0] AGE_SAT = '1;

    typedef struct packed {
        logic [CW-1:0] any_age;
        logic          flag;
        rule_e         rule;
        logic [BW-1:0] bank;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NB-1:0]         bank_open;
    logic [NB-1:0][CW-1:0] bank_age;
    logic [NB-1:0]         overrun;
    logic [NB-1:0]         pre_go, rw_go, act_go;
    logic                  req_viol;
    rule_e                 req_rule;
    logic [BW-1:0]         req_bank;
    cmd_e                  cmd_sel;
    logic                  ovr_hit;
    logic [BW-1:0]         ovr_bank;

    sdram_guard_arbiter #(.NB(NB), .CW(CW)) arb_i (
        .bank_open (bank_open),
        .bank_age  (bank_age),
        .any_age   (st_q.any_age),
        .t_rcd     (t_rcd),
        .t_rc      (t_rc),
        .t_rrd     (t_rrd),
        .pre_req   (pre_req),
        .pre_bank  (pre_bank),
        .rw_req    (rw_req),
        .rw_write  (rw_write),
        .rw_bank   (rw_bank),
        .act_req   (act_req),
        .act_bank  (act_bank),
        .pre_ack   (pre_ack),
        .rw_ack    (rw_ack),
        .act_ack   (act_ack),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_sel),
        .cmd_bank  (cmd_bank),
        .pre_go    (pre_go),
        .rw_go     (rw_go),
        .act_go    (act_go),
        .req_viol  (req_viol),
        .req_rule  (req_rule),
        .req_bank  (req_bank)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_timer #(.CW(CW)) timer_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go[b]),
            .pre_go    (pre_go[b]),
            .rw_go     (rw_go[b]),
            .t_rcd     (t_rcd),
            .t_rc      (t_rc),
            .t_ras_max (t_ras_max),
            .open_o    (bank_open[b]),
            .age_o     (bank_age[b]),
            .overrun_o (overrun[b])
        );
    end

    always_comb begin
        ovr_hit  = 1'b0;
        ovr_bank = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (overrun[i]) begin
                ovr_hit  = 1'b1;
                ovr_bank = BW'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.any_age != AGE_SAT) st_d.any_age = st_q.any_age + 1'b1;
        if (|act_go) st_d.any_age = CW'(1);
        if (!st_q.flag) begin
            if (req_viol) begin
                st_d.flag = 1'b1;
                st_d.rule = req_rule;
                st_d.bank = req_bank;
            end else if (ovr_hit) begin
                st_d.flag = 1'b1;
                st_d.rule = RULE_OVERRUN;
                st_d.bank = ovr_bank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.any_age <= AGE_SAT;
            st_q.flag    <= 1'b0;
            st_q.rule    <= RULE_NONE;
            st_q.bank    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_stall = pre_req && !pre_ack;
    assign rw_stall  = rw_req && !rw_ack;
    assign act_stall = act_req && !act_ack;
    assign cmd_code  = cmd_sel;
    assign force_pre = overrun;
    assign viol_flag = st_q.flag;
    assign viol_rule = st_q.rule;
    assign viol_bank = st_q.bank;

    assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_go) |-> (st_q.any_age >= t_rrd));

    assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> (viol_flag && $stable(viol_rule) && $stable(viol_bank)));

    assert_force_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        force_pre[0] |-> bank_open[0]);

    assert_one_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_go, rw_go, act_go}));

    assert_cmd_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (pre_ack || rw_ack || act_ack));

endmodule

// File: tb/sdram_act_guard_tb.sv
module sdram_act_guard_tb_top;
    localparam int NB = 4;
    localparam int CW = 8;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] t_rcd = 8'd1, t_rc = 8'd1, t_rrd = 8'd1, t_ras_max = 8'd255;
    logic          pre_req = 1'b0, rw_req = 1'b0, rw_write = 1'b0, act_req = 1'b0;
    logic [BW-1:0] pre_bank = '0, rw_bank = '0, act_bank = '0;
    logic          pre_ack, rw_ack, act_ack, pre_stall, rw_stall, act_stall;
    logic          cmd_valid, viol_flag;
    logic [1:0]    cmd_code, viol_rule;
    logic [BW-1:0] cmd_bank, viol_bank;
    logic [NB-1:0] force_pre;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_act_guard #(.NB(NB), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .t_rcd(t_rcd), .t_rc(t_rc), .t_rrd(t_rrd),
        .t_ras_max(t_ras_max), .pre_req(pre_req), .pre_bank(pre_bank),
        .rw_req(rw_req), .rw_write(rw_write), .rw_bank(rw_bank),
        .act_req(act_req), .act_bank(act_bank), .pre_ack(pre_ack),
        .rw_ack(rw_ack), .act_ack(act_ack), .pre_stall(pre_stall),
        .rw_stall(rw_stall), .act_stall(act_stall), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .force_pre(force_pre),
        .viol_flag(viol_flag), .viol_rule(viol_rule), .viol_bank(viol_bank)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pre_req = 1'b0; rw_req = 1'b0; act_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Called at a negedge; returns at a later negedge with the request dropped.
    task automatic do_act(input int b, output int gc);
        gc = -1;
        act_req = 1'b1; act_bank = BW'(b);
        for (int i = 0; i < 400; i++) begin
            #1;
            if (act_ack) begin gc = cyc; break; end
            @(negedge clk);
        end
        if (gc < 0) chk("activate never acknowledged (R9)", 0, 1);
        @(negedge clk);
        act_req = 1'b0;
    endtask

    task automatic do_rw(input int b, input bit wr, output int gc, output int stalls);
        gc = -1; stalls = 0;
        rw_req = 1'b1; rw_bank = BW'(b); rw_write = wr;
        for (int i = 0; i < 400; i++) begin
            #1;
            if (rw_ack) begin gc = cyc; break; end
            if (rw_stall) stalls++;
            @(negedge clk);
        end
        if (gc < 0) chk("access never acknowledged (R9)", 0, 1);
        else chk("R3 access cmd_code", int'(cmd_code), wr ? 2 : 1);
        @(negedge clk);
        rw_req = 1'b0;
    endtask

    initial begin
        int c0, c1, ns;
        do_reset();
        #1;
        chk("R1 reset cmd_valid", int'(cmd_valid), 0);
        chk("R1 reset viol_flag", int'(viol_flag), 0);
        chk("R1 reset force_pre", int'(force_pre), 0);
        chk("R1 reset stalls", int'({pre_stall, rw_stall, act_stall}), 0);
        @(negedge clk);
        act_req = 1'b1; act_bank = 2'd3;
        #1;
        chk("R1 first activate issued at once", int'(act_ack && cmd_valid), 1);
        chk("R1 first activate cmd_code", int'(cmd_code), 0);
        @(negedge clk);
        act_req = 1'b0;

        // R3 / R9: activate-to-access sweep
        for (int t = 1; t <= 6; t++) begin
            for (int b = 0; b < NB; b++) begin
                t_rcd = CW'(t); t_rc = 8'd1; t_rrd = 8'd1; t_ras_max = 8'd255;
                do_reset();
                do_act(b, c0);
                do_rw(b, (t + b) % 2 == 1, c1, ns);
                chk("R3 access latency", c1 - c0, t);
                chk("R9 stall windows before access", ns, t - 1);
            end
        end

        // R5: same-bank activate spacing
        for (int t = 2; t <= 8; t++) begin
            t_rcd = 8'd1; t_rc = CW'(t); t_rrd = 8'd1; t_ras_max = 8'd255;
            do_reset();
            do_act(t % NB, c0);
            pre_req = 1'b1; pre_bank = BW'(t % NB);
            #1;
            chk("R12 precharge issued", int'(cmd_valid && pre_ack && cmd_code == 2'd3), 1);
            @(negedge clk);
            pre_req = 1'b0;
            do_act(t % NB, c1);
            chk("R5 same-bank activate latency", c1 - c0, t);
        end

        // R6: any-bank activate spacing
        for (int t = 1; t <= 6; t++) begin
            t_rcd = 8'd1; t_rc = 8'd1; t_rrd = CW'(t); t_ras_max = 8'd255;
            do_reset();
            do_act(0, c0);
            do_act(1 + (t % 3), c1);
            chk("R6 cross-bank activate latency", c1 - c0, t);
        end

        // R8: all three requests in one window
        t_rcd = 8'd1; t_rc = 8'd1; t_rrd = 8'd1; t_ras_max = 8'd255;
        do_reset();
        do_act(0, c0);
        do_act(1, c1);
        repeat (3) @(negedge clk);
        pre_req = 1'b1; pre_bank = 2'd1;
        rw_req = 1'b1; rw_bank = 2'd0; rw_write = 1'b0;
        act_req = 1'b1; act_bank = 2'd2;
        #1;
        chk("R8 precharge wins", int'({cmd_valid, cmd_code, cmd_bank}), int'({1'b1, 2'd3, 2'd1}));
        chk("R8 losers stall", int'({rw_stall, act_stall}), 3);
        @(negedge clk);
        pre_req = 1'b0;
        #1;
        chk("R8 read second", int'({cmd_valid, cmd_code, cmd_bank}), int'({1'b1, 2'd1, 2'd0}));
        chk("R8 activate still stalled", int'(act_stall), 1);
        @(negedge clk);
        rw_req = 1'b0;
        #1;
        chk("R8 activate third", int'({cmd_valid, cmd_code, cmd_bank}), int'({1'b1, 2'd0, 2'd2}));
        @(negedge clk);
        act_req = 1'b0;

        // R2 / R10: access to idle bank, then a later violation is not recorded
        do_reset();
        rw_req = 1'b1; rw_bank = 2'd3; rw_write = 1'b1;
        #1;
        chk("R2 idle access acked without command", int'({rw_ack, cmd_valid}), 2);
        @(negedge clk);
        rw_req = 1'b0;
        #1;
        chk("R2 violation recorded", int'({viol_flag, viol_rule, viol_bank}), int'({1'b1, 2'd1, 2'd3}));
        @(negedge clk);
        do_act(0, c0);
        act_req = 1'b1; act_bank = 2'd0;
        #1;
        chk("R4 activate to open acked without command", int'({act_ack, cmd_valid}), 2);
        @(negedge clk);
        act_req = 1'b0;
        #1;
        chk("R10 first violation kept", int'({viol_flag, viol_rule, viol_bank}), int'({1'b1, 2'd1, 2'd3}));
        @(negedge clk);
        do_reset();
        #1;
        chk("R10 reset clears flag", int'(viol_flag), 0);
        @(negedge clk);

        // R4: activate to open bank recorded
        do_act(2, c0);
        act_req = 1'b1; act_bank = 2'd2;
        @(negedge clk);
        act_req = 1'b0;
        #1;
        chk("R4 violation recorded", int'({viol_flag, viol_rule, viol_bank}), int'({1'b1, 2'd2, 2'd2}));
        @(negedge clk);

        // R11: precharge to idle bank is a no-op that keeps the timer
        t_rc = 8'd10;
        do_reset();
        do_act(0, c0);
        pre_req = 1'b1; pre_bank = 2'd0;
        #1;
        chk("R12 precharge to open bank", int'({cmd_valid, cmd_code}), int'({1'b1, 2'd3}));
        @(negedge clk);
        #1;
        chk("R11 idle precharge acked without command", int'({pre_ack, cmd_valid}), 2);
        @(negedge clk);
        pre_req = 1'b0;
        do_act(0, c1);
        chk("R11 timer unchanged by no-op", c1 - c0, 10);
        chk("R11 no violation", int'(viol_flag), 0);

        // R7: open-time overrun
        t_rc = 8'd1; t_ras_max = 8'd5;
        do_reset();
        do_act(1, c0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        #1;
        chk("R7 no overrun at limit", int'(force_pre), 0);
        @(negedge clk);
        #1;
        chk("R7 overrun past limit", int'(force_pre), 2);
        chk("R7 flag not yet set", int'(viol_flag), 0);
        @(negedge clk);
        #1;
        chk("R7 overrun recorded", int'({viol_flag, viol_rule, viol_bank}), int'({1'b1, 2'd3, 2'd1}));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule